// File: doc/BRIEF.md
# Clock Multiplier Lockup-Wait Controller

This block holds one byte-wide control register and a lockup timer for an external ×4 clock multiplier. Software starts the multiplier by setting an enable bit. From then on a counter advances on each oscillator tick and measures the lockup interval. When the interval has elapsed, a read-only status bit rises, and software may then switch the system clock from the oscillator to the multiplied clock by setting a select bit.

The analog multiplier and the glitch-free clock mux are outside the block. They see only the `pll_en` and `clk_sel` outputs. The block guards the switch itself. A request to select the multiplied clock is dropped while lockup is still running, so `clk_sel` can never point at an unsettled clock. Clearing the enable bit returns everything to the oscillator and restarts the wait from zero.

The normal software sequence has three steps:
1. Write 0x80.
2. Poll until bit 5 reads 1.
3. Write 0xC0.

Top module: `pll_lock_ctrl`

## Requirements
- R1: After reset, `pll_en` and `clk_sel` are 0 and a read of the register returns 0x00.
- R2: The register answers only at byte address 0x10E8. Writes to any other address change nothing, and reads of any other address return 0x00.
- R3: The lockup flag (bit 5) reads 0 until exactly LOCK_CYCLES oscillator ticks have been sampled while enabled. It reads 1 from the clock edge of the last such tick. Ticks seen while disabled are not counted.
- R4: Once set, the lockup flag stays 1 for as long as the enable bit stays 1, whatever further ticks or writes arrive.
- R5: A write with bit 6 (select) = 1 and bit 7 = 1 sets `clk_sel` on the next edge only if the lockup flag is already 1 at that write. Otherwise the select bit is ignored and `clk_sel` stays 0.
- R6: A write of enable = 1 with select = 0 returns `clk_sel` to 0 and leaves the lockup flag untouched.
- R7: A write with bit 7 (enable) = 0 clears `pll_en` and `clk_sel` on the next edge and the lockup flag one edge later. A later re-enable waits the full LOCK_CYCLES ticks again.
- R8: Bits 4 to 0 always read as 0, and writing them has no effect.
- R9: A read at 0x10E8 returns `pll_en` in bit 7, `clk_sel` in bit 6 and the lockup flag in bit 5, in the same cycle as the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, zero when not addressed |
| osc_tick | input | 1 | One-cycle pulse per oscillator period, synchronous to clk |
| pll_en | output | 1 | Runs the external multiplier |
| clk_sel | output | 1 | 1 selects the multiplied clock, 0 the oscillator |

## Verification
A wrong count in the lockup timer shows up as bit 5 of a read rising one or more ticks early or late. The bench catches this on the first clock where a read is active near the end of the interval. A select register that is out of step with the lock state shows on `clk_sel` one edge after the offending write, and both outputs are compared against a behavioural model on every clock. A flag or counter that a disable fails to clear shows up after the next re-enable, as bit 5 reading 1 before the full interval has passed again.

// File: rtl/pll_ctrl_pkg.sv
package pll_ctrl_pkg;
  localparam int DATA_W   = 8;
  // bit positions software depends on
  localparam int BIT_EN   = 7;
  localparam int BIT_SEL  = 6;
  localparam int BIT_LOCK = 5;

  typedef struct packed {
    logic en;
    logic sel;
  } ctl_t;
endpackage

// File: rtl/pll_rst_sync.sv
module pll_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sh_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_st
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[i] <= 1'b0;
          else        sh_q[i] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[i] <= 1'b0;
          else        sh_q[i] <= sh_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_n_s = sh_q[STAGES-1];
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int LOCK_CYCLES = 65536
) (
  input  logic clk,
  input  logic rst_n_s,
  input  logic run,
  input  logic tick,
  output logic locked
);
  localparam int CNT_W = (LOCK_CYCLES > 2) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             cnt_ce;

  // register updates only when stopped, or when a tick arrives before lock
  assign cnt_ce = !run || (tick && !done_q);

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!run) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (tick && !done_q) begin
      if (cnt_q == LAST) done_d = 1'b1;
      else               cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (cnt_ce) begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign locked = done_q;

  // R4: lock holds while running
  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done_q && run) |=> done_q);
  // R7: stopping clears the flag
  p_stop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    !run |=> !done_q);
  // R3: lock never rises without a tick
  p_lock_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!done_q && !tick) |=> !done_q);
  // R4: counter frozen once locked
  p_cnt_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done_q && run) |=> $stable(cnt_q));
endmodule

// File: rtl/pll_ctl_reg.sv
module pll_ctl_reg
  import pll_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst_n_s,
  input  logic wr_hit,
  input  logic wr_en_bit,
  input  logic wr_sel_bit,
  input  logic locked,
  output ctl_t ctl
);
  ctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_hit) begin
      ctl_d.en  = wr_en_bit;
      // select honoured only with enable set and lock already reached
      ctl_d.sel = wr_en_bit & wr_sel_bit & locked;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    ctl_q <= '0;
    else if (wr_hit) ctl_q <= ctl_d;
  end

  assign ctl = ctl_q;

  // R5: never select an unlocked clock
  p_sel_locked_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctl_q.sel |-> locked);
  // R7: select implies enable
  p_sel_en_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctl_q.sel |-> ctl_q.en);
  // R2: no write, no change
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!wr_hit && ctl_q.en) |=> ctl_q.en);
  // R5: select rises only through a write while locked
  p_sel_rise_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ctl_q.sel && !(wr_hit && locked)) |=> !ctl_q.sel);
endmodule

// File: rtl/pll_bus_port.sv
module pll_bus_port
  import pll_ctrl_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(16'h10E8)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  ctl_t              ctl,
  input  logic              locked,
  output logic              wr_hit,
  output logic [DATA_W-1:0] rdata
);
  logic sel_me;

  assign sel_me = (addr == REG_ADDR);
  assign wr_hit = wr && sel_me;

  always_comb begin
    rdata = '0;
    if (rd && sel_me) begin
      rdata[BIT_EN]   = ctl.en;
      rdata[BIT_SEL]  = ctl.sel;
      rdata[BIT_LOCK] = locked;
    end
  end
endmodule

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl
  import pll_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int REG_ADDR    = 16'h10E8,
  parameter int LOCK_CYCLES = 65536,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              osc_tick,
  output logic              pll_en,
  output logic              clk_sel
);
  logic rst_n_s;
  logic wr_hit;
  logic locked;
  ctl_t ctl;
  logic unused_wbits;

  assign unused_wbits = ^bus_wdata[BIT_LOCK:0];

  pll_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  pll_bus_port #(.ADDR_W(ADDR_W), .REG_ADDR(ADDR_W'(REG_ADDR))) u_bus (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .ctl(ctl),
    .locked(locked), .wr_hit(wr_hit), .rdata(bus_rdata)
  );

  pll_ctl_reg u_reg (
    .clk(clk), .rst_n_s(rst_n_s), .wr_hit(wr_hit),
    .wr_en_bit(bus_wdata[BIT_EN]), .wr_sel_bit(bus_wdata[BIT_SEL]),
    .locked(locked), .ctl(ctl)
  );

  pll_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_tmr (
    .clk(clk), .rst_n_s(rst_n_s), .run(ctl.en), .tick(osc_tick),
    .locked(locked)
  );

  assign pll_en  = ctl.en;
  assign clk_sel = ctl.sel;

  // R8: low bits always read zero
  p_low_zero_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_rdata[4:0] == 5'd0);
  // R7: disabling write drops select next edge
  p_dis_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_hit && !bus_wdata[BIT_EN]) |=> (!clk_sel && !pll_en));
endmodule

// File: tb/sim_pll_lock_ctrl.sv
module sim_pll_lock_ctrl;
  localparam int LOCK = 20;
  localparam logic [15:0] A = 16'h10E8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, osc_tick = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic pll_en, clk_sel;

  int n_cmp = 0, n_bad = 0;
  bit cmp_on = 0;

  // behavioural model state
  int m_en = 0, m_sel = 0, m_done = 0, m_ticks = 0;

  always #2.5 clk = ~clk;

  pll_lock_ctrl #(.LOCK_CYCLES(LOCK)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .osc_tick(osc_tick), .pll_en(pll_en), .clk_sel(clk_sel)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_read(input logic rd, input logic [15:0] ad);
    if (rd && ad == A) return {m_en[0], m_sel[0], m_done[0], 5'd0};
    return 8'h00;
  endfunction

  // model: ticks counted while enabled; flag on LOCK-th tick
  always @(posedge clk) begin
    int ne, ns, nd, nt;
    if (rst_n) begin
      ne = m_en; ns = m_sel; nd = m_done; nt = m_ticks;
      if (m_en == 0) begin nt = 0; nd = 0; end
      else if (osc_tick && m_done == 0) begin
        nt = m_ticks + 1;
        if (nt == LOCK) nd = 1;
      end
      if (bus_wr && bus_addr == A) begin
        ne = bus_wdata[7];
        ns = (bus_wdata[7] && bus_wdata[6] && m_done == 1) ? 1 : 0;
      end
      m_en = ne; m_sel = ns; m_done = nd; m_ticks = nt;
    end
  end

  // every-clock comparison
  always @(posedge clk) begin
    #1;
    if (cmp_on) begin
      chk("R7 pll_en", {7'd0, pll_en}, {7'd0, m_en[0]});
      chk("R5 clk_sel", {7'd0, clk_sel}, {7'd0, m_sel[0]});
      chk("R9 rdata", bus_rdata, m_read(bus_rd, bus_addr));
    end
  end

  task automatic wr(input logic [15:0] ad, input logic [7:0] d);
    @(negedge clk); bus_addr = ad; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] ad, output logic [7:0] v);
    bus_addr = ad; bus_rd = 1'b1; #1; v = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin @(negedge clk); osc_tick = 1'b1; end
    @(negedge clk); osc_tick = 1'b0;
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    chk("R1 pll_en in reset", {7'd0, pll_en}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1;
    rd(A, v); chk("R1 reset read", v, 8'h00);
    chk("R1 clk_sel", {7'd0, clk_sel}, 8'h00);

    // R2: other addresses
    wr(16'h10E9, 8'hC0);
    chk("R2 wrong-addr write", {6'd0, pll_en, clk_sel}, 8'h00);
    wr(16'h00E8, 8'h80);
    chk("R2 wrong-addr write 2", {6'd0, pll_en, clk_sel}, 8'h00);

    // ticks while disabled not counted (R3)
    ticks(30);

    // R5: select before lock ignored; R8 low bits
    wr(A, 8'hFF);
    chk("R5 sel ignored before lock", {6'd0, pll_en, clk_sel}, 8'h02);
    rd(A, v); chk("R8 low bits zero", v, 8'h80);
    rd(16'h10E9, v); chk("R2 wrong-addr read", v, 8'h00);

    // R3: exact interval
    ticks(LOCK - 1);
    rd(A, v); chk("R3 flag low one tick early", v, 8'h80);
    ticks(1);
    rd(A, v); chk("R3 flag set at LOCK ticks", v, 8'hA0);

    // R4: holds
    ticks(50);
    wr(A, 8'h9F);
    rd(A, v); chk("R4 flag held", v, 8'hA0);

    // R5/R9: select after lock
    wr(A, 8'hC0);
    rd(A, v); chk("R9 read shows sel", v, 8'hE0);
    chk("R5 clk_sel set after lock", {7'd0, clk_sel}, 8'h01);

    // R6: back to oscillator keeping lock
    wr(A, 8'h80);
    rd(A, v); chk("R6 sel cleared, lock kept", v, 8'hA0);
    wr(A, 8'hC0);

    // R7: disable clears all
    wr(A, 8'h40);
    chk("R7 outputs cleared", {6'd0, pll_en, clk_sel}, 8'h00);
    @(negedge clk);
    rd(A, v); chk("R7 flag cleared", v, 8'h00);
    wr(A, 8'h80);
    ticks(LOCK - 1);
    rd(A, v); chk("R7 restart full wait", v, 8'h80);
    ticks(1);
    rd(A, v); chk("R7 relock", v, 8'hA0);

    // mixed traffic against model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      bus_wr    = ($urandom % 10) == 0;
      bus_rd    = ($urandom % 2) == 0;
      case ($urandom % 6)
        0: bus_addr = 16'h10E9;
        1: bus_addr = 16'h00E8;
        default: bus_addr = A;
      endcase
      bus_wdata = {($urandom % 8) != 0, 1'($urandom), 6'($urandom)};
      osc_tick  = 1'($urandom);
    end
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; osc_tick = 1'b0;
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule